// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block tracks which power state a small processor core is in and drives three clock enables to match: one for the core, one for the on-chip peripherals (serial units and timers), and one for the clock output pin. Software can stop only the peripherals by raising a halt control bit. A sleep-instruction pulse then selects one of three deeper states: plain sleep (core stopped, peripherals running), system stop (core and peripherals stopped, clock pin still toggling) or idle (every internal clock and the clock pin blocked).

The halt bit, the two mode-select bits and the bus-release bit are captured only at the sleep pulse. Writes made while the core is stopped therefore cannot change the state it is in. Each stop state has its own wake sources. A wake event starts a fixed restart delay, and at its end the core clock returns together with a one-cycle wake pulse. A companion flag on that pulse says whether the core must service an interrupt or simply resume at the instruction after the sleep instruction. External bus requests are answered on a registered grant, which idle withholds unless bus release was enabled before entry.

All pins are plain level or pulse controls. No stream interface exists, so no back-pressure rules apply.

Top module: `lpm_sequencer`

## Requirements
- R1: rst_n low forces the running state at once: core, peripheral and clock-pin enables at 1, wake_pulse, wake_service and bus_grant at 0. From any stop state, no wake pulse follows.
- R2: With no sleep pulse, periph_halt=1 in the running state clears periph_clk_en from the next cycle while core_clk_en and clkout_en stay 1. periph_halt=0 restores it the cycle after.
- R3: A sleep pulse with periph_halt=0 enters sleep from the next cycle: core_clk_en=0, periph_clk_en=1, clkout_en=1.
- R4: A sleep pulse with periph_halt=1 and mode_sel other than 2'b10 enters system stop: core_clk_en=0, periph_clk_en=0, clkout_en=1.
- R5: A sleep pulse with periph_halt=1 and mode_sel=2'b10 enters idle: all three enables at 0.
- R6: Any stop state wakes on nmi=1 or on irq_req[i]=1 with irq_en[i]=1. unit_irq (an on-chip peripheral request) wakes sleep only, never system stop or idle. An irq_req line whose enable is 0 never wakes.
- R7: core_clk_en returns exactly 2 cycles after the clock edge that samples the wake from sleep or system stop, and exactly 10 cycles after it from idle. During the delay clkout_en=1 and periph_clk_en=1 only if periph_halt was 0 at the sleep pulse.
- R8: wake_pulse is 1 for the single cycle in which core_clk_en first returns. wake_service is 1 on that cycle if the wake included nmi, or an enabled request with gie=1, and 0 otherwise. wake_service is 0 on every other cycle.
- R9: bus_grant equals bus_req of the previous cycle. The exception is idle, where it stays 0 unless bus_rel_en was 1 at the sleep pulse.
- R10: mode_sel, periph_halt and bus_rel_en changes made while stopped or restarting do not change the current state or the idle grant rule. A sleep pulse outside the running states is ignored.
- R11: After the restart delay the block returns to peripheral stop if periph_halt is 1 at that time, otherwise to full run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, also a wake source |
| periph_halt | input | 1 | Peripheral halt control bit |
| mode_sel | input | 2 | Stop-mode select bits, 2'b10 selects idle |
| bus_rel_en | input | 1 | Allow bus grant while idle |
| slp_pulse | input | 1 | One-cycle pulse on sleep-instruction execution |
| nmi | input | 1 | Non-maskable interrupt request |
| irq_req | input | N_IRQ | Maskable external interrupt requests |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| unit_irq | input | 1 | Combined on-chip peripheral interrupt request |
| gie | input | 1 | Global interrupt-enable flag |
| bus_req | input | 1 | External bus master request |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| clkout_en | output | 1 | Clock output pin enable |
| bus_grant | output | 1 | Registered bus grant |
| wake_pulse | output | 1 | One-cycle pulse when the core restarts |
| wake_service | output | 1 | With wake_pulse: 1 = service interrupt, 0 = plain resume |

## Verification
A wrong internal state shows on the three clock enables in the cycle after the edge that took it. A mis-decoded stop mode is therefore visible one cycle after the sleep pulse. A wrong restart count shows as core_clk_en returning early or late, which is caught within at most ten cycles of the wake. A wrong captured bus-release or service bit stays hidden until a bus request in idle or the wake pulse reveals it, so the bench drives both inside each stop state.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_SLEEP    = 3'd1,
    ST_IO_STOP  = 3'd2,
    ST_SYS_STOP = 3'd3,
    ST_IDLE     = 3'd4,
    ST_RESTART  = 3'd5
  } lpm_state_e;

  typedef struct packed {
    logic core;
    logic periph;
    logic clkout;
  } lpm_gate_t;
endpackage

// File: rtl/lpm_mode_decode.sv
module lpm_mode_decode
  import lpm_pkg::*;
#(
  parameter logic [1:0] IDLE_CODE = 2'b10
) (
  input  logic       halt,
  input  logic [1:0] mode_sel,
  output lpm_state_e target
);
  // Stop state chosen by a sleep pulse.
  always_comb begin
    if (!halt)                       target = ST_SLEEP;
    else if (mode_sel == IDLE_CODE)  target = ST_IDLE;
    else                             target = ST_SYS_STOP;
  end
endmodule

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect
  import lpm_pkg::*;
#(
  parameter int N_IRQ = 3
) (
  input  lpm_state_e       state,
  input  logic             nmi,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             unit_irq,
  input  logic             gie,
  output logic             wake,
  output logic             service
);
  logic [N_IRQ-1:0] line_hit;
  logic             ext_hit;
  logic             unit_hit;
  logic             stopped;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    assign line_hit[i] = irq_req[i] & irq_en[i];
  end

  assign ext_hit  = |line_hit;
  // Peripheral requests are dead once the peripheral clock is stopped.
  assign unit_hit = unit_irq & (state == ST_SLEEP);
  assign stopped  = (state == ST_SLEEP) || (state == ST_SYS_STOP) || (state == ST_IDLE);

  assign wake    = stopped & (nmi | ext_hit | unit_hit);
  assign service = nmi | (gie & (ext_hit | unit_hit));
endmodule

// File: rtl/lpm_restart_timer.sv
module lpm_restart_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/lpm_gate_map.sv
module lpm_gate_map
  import lpm_pkg::*;
(
  input  lpm_state_e state,
  input  logic       halt_lat,
  output lpm_gate_t  gate
);
  always_comb begin
    unique case (state)
      ST_RUN:      gate = '{core: 1'b1, periph: 1'b1,      clkout: 1'b1};
      ST_IO_STOP:  gate = '{core: 1'b1, periph: 1'b0,      clkout: 1'b1};
      ST_SLEEP:    gate = '{core: 1'b0, periph: 1'b1,      clkout: 1'b1};
      ST_SYS_STOP: gate = '{core: 1'b0, periph: 1'b0,      clkout: 1'b1};
      ST_IDLE:     gate = '{core: 1'b0, periph: 1'b0,      clkout: 1'b0};
      ST_RESTART:  gate = '{core: 1'b0, periph: !halt_lat, clkout: 1'b1};
      default:     gate = '{core: 1'b1, periph: 1'b1,      clkout: 1'b1};
    endcase
  end
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int         N_IRQ     = 3,
  parameter int         SLEEP_LAT = 2,
  parameter int         IDLE_LAT  = 10,
  parameter logic [1:0] IDLE_CODE = 2'b10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             periph_halt,
  input  logic [1:0]       mode_sel,
  input  logic             bus_rel_en,
  input  logic             slp_pulse,
  input  logic             nmi,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             unit_irq,
  input  logic             gie,
  input  logic             bus_req,
  output logic             core_clk_en,
  output logic             periph_clk_en,
  output logic             clkout_en,
  output logic             bus_grant,
  output logic             wake_pulse,
  output logic             wake_service
);
  localparam int MAX_LAT = (IDLE_LAT > SLEEP_LAT) ? IDLE_LAT : SLEEP_LAT;
  localparam int CW      = $clog2(MAX_LAT + 1);
  localparam logic [CW-1:0] IDLE_LD  = CW'(IDLE_LAT - 1);
  localparam logic [CW-1:0] SLEEP_LD = CW'(SLEEP_LAT - 1);

  lpm_state_e state_q, state_d, target;
  logic       halt_lat, rel_lat, svc_q;
  logic       wake, service, tmr_done, accept_slp, leave;
  logic       grant_q, pulse_q, serv_q;
  lpm_gate_t  gate;

  lpm_mode_decode #(.IDLE_CODE(IDLE_CODE)) u_dec (
    .halt     (periph_halt),
    .mode_sel (mode_sel),
    .target   (target)
  );

  lpm_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
    .state    (state_q),
    .nmi      (nmi),
    .irq_req  (irq_req),
    .irq_en   (irq_en),
    .unit_irq (unit_irq),
    .gie      (gie),
    .wake     (wake),
    .service  (service)
  );

  lpm_restart_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wake),
    .load_val ((state_q == ST_IDLE) ? IDLE_LD : SLEEP_LD),
    .done     (tmr_done)
  );

  lpm_gate_map u_gate (
    .state    (state_q),
    .halt_lat (halt_lat),
    .gate     (gate)
  );

  assign accept_slp = slp_pulse && ((state_q == ST_RUN) || (state_q == ST_IO_STOP));
  assign leave      = (state_q == ST_RESTART) && tmr_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN, ST_IO_STOP: begin
        if (slp_pulse)        state_d = target;
        else if (periph_halt) state_d = ST_IO_STOP;
        else                  state_d = ST_RUN;
      end
      ST_SLEEP, ST_SYS_STOP, ST_IDLE: begin
        if (wake) state_d = ST_RESTART;
      end
      ST_RESTART: begin
        if (tmr_done) state_d = periph_halt ? ST_IO_STOP : ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      halt_lat <= 1'b0;
      rel_lat  <= 1'b0;
      svc_q    <= 1'b0;
      grant_q  <= 1'b0;
      pulse_q  <= 1'b0;
      serv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_slp) begin
        halt_lat <= periph_halt;
        rel_lat  <= bus_rel_en;
      end
      if (wake) svc_q <= service;
      pulse_q <= leave;
      serv_q  <= leave & svc_q;
      grant_q <= bus_req & ((state_q != ST_IDLE) | rel_lat);
    end
  end

  assign core_clk_en   = gate.core;
  assign periph_clk_en = gate.periph;
  assign clkout_en     = gate.clkout;
  assign bus_grant     = grant_q;
  assign wake_pulse    = pulse_q;
  assign wake_service  = serv_q;
endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk
  import lpm_pkg::*;
#(
  parameter int N_IRQ = 3
) (
  input logic             clk,
  input logic             rst_n,
  input lpm_state_e       state_q,
  input logic             rel_lat,
  input logic             nmi,
  input logic [N_IRQ-1:0] irq_req,
  input logic [N_IRQ-1:0] irq_en,
  input logic             core_clk_en,
  input logic             periph_clk_en,
  input logic             clkout_en,
  input logic             bus_grant,
  input logic             wake_pulse,
  input logic             wake_service
);
  a_r2_io_stop_gates: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IO_STOP |-> core_clk_en && !periph_clk_en && clkout_en);

  a_r5_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IDLE |-> !core_clk_en && !periph_clk_en && !clkout_en);

  a_r6_sys_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SYS_STOP && !nmi && (irq_req & irq_en) == '0) |=> state_q == ST_SYS_STOP);

  a_r7_restart_core_off: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_RESTART |-> !core_clk_en && clkout_en);

  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  a_r8_service_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_service |-> wake_pulse && core_clk_en);

  a_r9_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !rel_lat) |=> !bus_grant);

  a_r10_rel_held: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IDLE |=> $stable(rel_lat));
endmodule

bind lpm_sequencer lpm_sequencer_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .state_q       (state_q),
  .rel_lat       (rel_lat),
  .nmi           (nmi),
  .irq_req       (irq_req),
  .irq_en        (irq_en),
  .core_clk_en   (core_clk_en),
  .periph_clk_en (periph_clk_en),
  .clkout_en     (clkout_en),
  .bus_grant     (bus_grant),
  .wake_pulse    (wake_pulse),
  .wake_service  (wake_service)
);

// File: tb/sim_lpm_sequencer.sv
`timescale 1ns/1ps
module sim_lpm_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       periph_halt = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       bus_rel_en = 1'b0;
  logic       slp_pulse = 1'b0;
  logic       nmi = 1'b0;
  logic [2:0] irq_req = 3'b000;
  logic [2:0] irq_en = 3'b000;
  logic       unit_irq = 1'b0;
  logic       gie = 1'b0;
  logic       bus_req = 1'b0;
  logic       core_clk_en, periph_clk_en, clkout_en, bus_grant, wake_pulse, wake_service;

  int checks = 0;
  int errors = 0;

  // Reference model: 0 run, 1 periph stop, 2 sleep, 3 system stop, 4 idle, 5 restart
  int m_st = 0, m_cnt = 0;
  bit m_halt = 0, m_rel = 0, m_svc = 0, m_pulse = 0, m_serv = 0, m_grant = 0;

  always #4 clk = ~clk;

  lpm_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .periph_halt(periph_halt), .mode_sel(mode_sel),
    .bus_rel_en(bus_rel_en), .slp_pulse(slp_pulse), .nmi(nmi), .irq_req(irq_req),
    .irq_en(irq_en), .unit_irq(unit_irq), .gie(gie), .bus_req(bus_req),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .clkout_en(clkout_en),
    .bus_grant(bus_grant), .wake_pulse(wake_pulse), .wake_service(wake_service)
  );

  task automatic chk(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit ext, w;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_halt = 0; m_rel = 0; m_svc = 0;
      m_pulse = 0; m_serv = 0; m_grant = 0;
      return;
    end
    m_grant = bus_req && (m_st != 4 || m_rel);
    m_pulse = 0;
    m_serv  = 0;
    ext = (irq_req & irq_en) != 0;
    if (m_st == 0 || m_st == 1) begin
      if (slp_pulse) begin
        m_halt = periph_halt;
        m_rel  = bus_rel_en;
        if (!periph_halt) m_st = 2;
        else if (mode_sel == 2'b10) m_st = 4;
        else m_st = 3;
      end else m_st = periph_halt ? 1 : 0;
    end else if (m_st == 5) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_st = periph_halt ? 1 : 0;
        m_pulse = 1;
        m_serv = m_svc;
      end
    end else begin
      w = nmi || ext || (m_st == 2 && unit_irq);
      if (w) begin
        m_svc = nmi || (gie && (ext || (m_st == 2 && unit_irq)));
        m_cnt = (m_st == 4) ? 10 : 2;
        m_st = 5;
      end
    end
  endtask

  function automatic string st_tag(int s);
    case (s)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic compare();
    int e_core, e_per, e_clk;
    e_core = (m_st == 0 || m_st == 1);
    e_per  = (m_st == 0 || m_st == 2 || (m_st == 5 && !m_halt));
    e_clk  = (m_st != 4);
    chk(core_clk_en,   e_core,  st_tag(m_st), "core_clk_en");
    chk(periph_clk_en, e_per,   st_tag(m_st), "periph_clk_en");
    chk(clkout_en,     e_clk,   st_tag(m_st), "clkout_en");
    chk(bus_grant,     m_grant, "R9", "bus_grant");
    chk(wake_pulse,    m_pulse, "R8", "wake_pulse");
    chk(wake_service,  m_serv,  "R8", "wake_service");
  endtask

  task automatic tick();
    @(negedge clk);
    model_step();
    compare();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic sleep_now(input bit halt, input logic [1:0] ms, input bit rel);
    periph_halt = halt; mode_sel = ms; bus_rel_en = rel; slp_pulse = 1'b1;
    tick();
    slp_pulse = 1'b0;
  endtask

  task automatic wake_latency(input int lat, input int svc, input string tag);
    int k = 0;
    do begin
      tick();
      k++;
    end while (!core_clk_en && k < 40);
    chk(k, lat + 1, tag, "restart latency");
    chk(wake_pulse, 1, "R8", "pulse on core return");
    chk(wake_service, svc, "R8", "service flag");
    nmi = 0; irq_req = 0; unit_irq = 0;
  endtask

  initial begin
    ticks(3);
    chk(core_clk_en & periph_clk_en & clkout_en, 1, "R1", "enables in reset");
    chk(wake_pulse | wake_service | bus_grant, 0, "R1", "flags in reset");
    rst_n = 1'b1;
    ticks(2);

    // R2 peripheral-only stop
    periph_halt = 1; tick();
    chk(periph_clk_en, 0, "R2", "periph stopped");
    chk(core_clk_en, 1, "R2", "core keeps running");
    periph_halt = 0; tick();
    chk(periph_clk_en, 1, "R2", "periph restarted");

    // R3 sleep, R6 masked line ignored, R9 grant follows request
    irq_en = 3'b001; gie = 1;
    sleep_now(0, 2'b00, 0);
    chk(core_clk_en, 0, "R3", "core stopped in sleep");
    bus_req = 1; ticks(2);
    chk(bus_grant, 1, "R9", "grant in sleep");
    bus_req = 0;
    irq_req = 3'b010; ticks(3);
    chk(core_clk_en, 0, "R6", "masked line does not wake");
    irq_req = 0; unit_irq = 1;
    wake_latency(2, 1, "R7");

    // R4 system stop: unit request ignored, enabled line with gie=0 resumes, R11 back to halt
    gie = 0;
    sleep_now(1, 2'b01, 0);
    chk(periph_clk_en | core_clk_en, 0, "R4", "system stop gates");
    unit_irq = 1; ticks(4);
    chk(core_clk_en, 0, "R6", "unit request ignored in system stop");
    unit_irq = 0; irq_req = 3'b001;
    wake_latency(2, 0, "R7");
    chk(periph_clk_en, 0, "R11", "returns to peripheral stop");
    periph_halt = 0; ticks(2);

    // R5 idle, R9 grant withheld, R10 writes while idle ignored
    gie = 1;
    sleep_now(1, 2'b10, 0);
    chk(clkout_en, 0, "R5", "clock pin blocked");
    bus_req = 1; mode_sel = 2'b00; periph_halt = 0; bus_rel_en = 1; slp_pulse = 1;
    ticks(3);
    slp_pulse = 0;
    chk(bus_grant, 0, "R10", "release bit sampled only at entry");
    chk(clkout_en, 0, "R10", "mode unchanged by writes");
    unit_irq = 1; ticks(2);
    chk(core_clk_en, 0, "R6", "unit request ignored in idle");
    unit_irq = 0; nmi = 1; gie = 0;
    wake_latency(10, 1, "R7");
    chk(periph_clk_en, 1, "R11", "returns to full run");
    bus_req = 0; ticks(2);

    // idle with release allowed, enabled line with gie=1
    gie = 1; irq_en = 3'b100;
    sleep_now(1, 2'b10, 1);
    bus_req = 1; ticks(2);
    chk(bus_grant, 1, "R9", "grant in idle with release");
    bus_req = 0; irq_req = 3'b100;
    wake_latency(10, 1, "R7");
    ticks(2);

    // R10 sleep pulse during restart ignored
    sleep_now(0, 2'b00, 0);
    nmi = 1; tick(); nmi = 0;
    slp_pulse = 1; tick(); slp_pulse = 0;
    ticks(2);
    chk(core_clk_en, 1, "R10", "sleep pulse during restart ignored");
    ticks(2);

    // R1 reset while idle: back to run at once, no pulse
    sleep_now(1, 2'b10, 0);
    ticks(2);
    @(negedge clk); rst_n = 0;
    tick();
    chk(core_clk_en & clkout_en, 1, "R1", "reset leaves idle");
    chk(wake_pulse, 0, "R1", "no pulse on reset exit");
    rst_n = 1;
    ticks(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule